// File: doc/BRIEF.md
# Profile Bank Selector

The block keeps four identical banks of datapath control parameters and drives the fields of one of them, chosen by a two-bit profile select input. Each bank holds a frequency tuning word, a spectral invert flag, an inverse-CIC bypass flag, a CIC interpolation rate (where one code means bypass) and an unsigned output scale factor. A small register write port loads any bank at any time, whether or not that bank is active.

The select inputs are sampled in the domain that suits the operating mode. In single-tone mode they are taken on every system clock. In quadrature modulation and interpolating DAC modes they are taken only on cycles flagged by a parallel-data-clock enable. The sampled select passes through a two-stage synchronizer and then loads one bank index register. Every output field is read from the bank that this one register names, so a profile change switches the whole parameter set at the same edge.

Top module: `prof_select_top`

## Requirements
- R1: After reset the active bank is 0 and every bank holds tuning word 0, spectral invert 0, inverse-CIC bypass 0, CIC rate 1 and scale 0x80 (unity).
- R2: The select input `ps_i` is a binary bank index with bit 1 as the MSB: 00 picks bank 0, 01 bank 1, 10 bank 2 and 11 bank 3. `active_o` reports the picked index.
- R3: With `mode_i` at 0 (single tone) or 3 (treated as single tone), the select is sampled on every clock. A new select value driven before rising edge k shows on the outputs after edge k+2 and not before.
- R4: With `mode_i` at 1 (quadrature) or 2 (interpolating DAC), the select is sampled only at edges where `pdclk_en_i` is high. The new bank shows after the third such edge, and edges with `pdclk_en_i` low leave `active_o` unchanged.
- R5: All fields of the newly active bank appear in the same cycle. No cycle shows a mix of old and new fields.
- R6: A write with `wr_addr_i`=0 loads `wr_data_i[FTW_W-1:0]` as the tuning word. A write with `wr_addr_i`=1 loads the control word: bit 0 spectral invert, bit 1 inverse-CIC bypass, bits 13:8 CIC rate, bits 23:16 scale. A write to the active bank is visible on the outputs in the cycle after the write edge.
- R7: A write to a bank that is not active leaves every output unchanged.
- R8: `spec_inv_o` follows the active bank's invert flag only when `mode_i` is 1 (quadrature). In any other mode it is 0.
- R9: A CIC rate code of 0 means bypass and raises `cic_byp_o`. Codes 1 to 63 leave `cic_byp_o` low and pass unchanged on `cic_rate_o`.
- R10: The scale factor is an unsigned 8-bit value with 1 integer bit and 7 fraction bits (0 to 1.9921875). It is passed unchanged on `scale_o`, including the codes 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode: 0 tone, 1 quadrature, 2 interpolating DAC, 3 tone |
| pdclk_en_i | input | 1 | Parallel data clock enable, one system cycle per data clock |
| ps_i | input | 2 | Profile select, bit 1 MSB |
| wr_en_i | input | 1 | Register write strobe |
| wr_bank_i | input | 2 | Bank targeted by the write |
| wr_addr_i | input | 1 | 0 tuning word, 1 control word |
| wr_data_i | input | WR_W (32) | Write data |
| active_o | output | 2 | Index of the bank in use |
| ftw_o | output | FTW_W (32) | Active frequency tuning word |
| spec_inv_o | output | 1 | Spectral invert, qualified by mode |
| inv_cic_byp_o | output | 1 | Inverse-CIC bypass flag |
| cic_byp_o | output | 1 | CIC interpolator bypass |
| cic_rate_o | output | 6 | CIC interpolation rate |
| scale_o | output | 8 | Output scale factor, U1.7 |

## Verification
On every cycle the assertions check four things. The invert output stays low outside quadrature mode. The bank index holds on parallel-clock cycles without an enable. A write to the active bank reaches the tuning word one cycle later, and outputs hold steady when there is neither a write nor a bank change. After three steady tone-mode cycles the index equals the select input. The bench scenarios are needed for the rest. They show the exact three-sample latency in each mode and that every field of a bank switches in the same cycle. They also show the control-word field layout and that writes to idle banks are invisible.

// File: rtl/prof_pkg.sv
package prof_pkg;

    localparam int unsigned RATE_W  = 6;
    localparam int unsigned SCALE_W = 8;
    localparam int unsigned CTRL_W  = 24;

    typedef enum logic [1:0] {
        MODE_TONE = 2'd0,
        MODE_QUAD = 2'd1,
        MODE_IDAC = 2'd2,
        MODE_RSVD = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic               inv;
        logic               icb;
        logic [RATE_W-1:0]  rate;
        logic [SCALE_W-1:0] scale;
    } bank_ctrl_t;

    localparam bank_ctrl_t CTRL_RST = '{inv: 1'b0, icb: 1'b0,
                                        rate: RATE_W'(1), scale: SCALE_W'(8'h80)};

    function automatic bank_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        bank_ctrl_t c;
        c.inv   = w[0];
        c.icb   = w[1];
        c.rate  = w[8 +: RATE_W];
        c.scale = w[16 +: SCALE_W];
        return c;
    endfunction

    function automatic logic uses_pdclk(input op_mode_e m);
        return (m == MODE_QUAD) || (m == MODE_IDAC);
    endfunction

endpackage

// File: rtl/prof_sync.sv
module prof_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            st_d[i] = st_q[i];
        end
        if (en_i) begin
            st_d[0] = d_i;
            for (int i = 1; i < STAGES; i++) begin
                st_d[i] = st_q[i-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/prof_bank_file.sv
module prof_bank_file
    import prof_pkg::*;
#(
    parameter int unsigned FTW_W = 32,
    parameter int unsigned NBANK = 4,
    parameter int unsigned WR_W  = 32,
    localparam int unsigned SEL_W = $clog2(NBANK)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [SEL_W-1:0]              wr_bank_i,
    input  logic                          wr_addr_i,
    input  logic [WR_W-1:0]               wr_data_i,
    output logic [NBANK-1:0][FTW_W-1:0]   ftw_o,
    output bank_ctrl_t [NBANK-1:0]        ctrl_o
);

    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        bank_ctrl_t       ctrl;
    } bank_t;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        bank_t bank_d, bank_q;
        logic  hit;

        assign hit = wr_en_i && (wr_bank_i == SEL_W'(g));

        always_comb begin
            bank_d = bank_q;
            if (hit && !wr_addr_i) begin
                bank_d.ftw = wr_data_i[FTW_W-1:0];
            end
            if (hit && wr_addr_i) begin
                bank_d.ctrl = unpack_ctrl(wr_data_i[CTRL_W-1:0]);
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                bank_q.ftw  <= '0;
                bank_q.ctrl <= CTRL_RST;
            end else begin
                bank_q <= bank_d;
            end
        end

        assign ftw_o[g]  = bank_q.ftw;
        assign ctrl_o[g] = bank_q.ctrl;
    end

endmodule

// File: rtl/prof_select_top.sv
module prof_select_top
    import prof_pkg::*;
#(
    parameter int unsigned FTW_W       = 32,
    parameter int unsigned NBANK       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SEL_W = $clog2(NBANK),
    localparam int unsigned WR_W  = (FTW_W > CTRL_W) ? FTW_W : CTRL_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         mode_i,
    input  logic               pdclk_en_i,
    input  logic [SEL_W-1:0]   ps_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   wr_bank_i,
    input  logic               wr_addr_i,
    input  logic [WR_W-1:0]    wr_data_i,
    output logic [SEL_W-1:0]   active_o,
    output logic [FTW_W-1:0]   ftw_o,
    output logic               spec_inv_o,
    output logic               inv_cic_byp_o,
    output logic               cic_byp_o,
    output logic [RATE_W-1:0]  cic_rate_o,
    output logic [SCALE_W-1:0] scale_o
);

    typedef struct packed {
        logic [SEL_W-1:0] idx;
    } sel_state_t;

    op_mode_e                   mode;
    logic                       samp_en;
    logic [SEL_W-1:0]           ps_sync;
    logic [NBANK-1:0][FTW_W-1:0] ftw_all;
    bank_ctrl_t [NBANK-1:0]     ctrl_all;
    bank_ctrl_t                 act_ctrl;
    sel_state_t                 st_d, st_q;

    assign mode    = op_mode_e'(mode_i);
    assign samp_en = uses_pdclk(mode) ? pdclk_en_i : 1'b1;

    prof_sync #(
        .W      (SEL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (samp_en),
        .d_i    (ps_i),
        .q_o    (ps_sync)
    );

    prof_bank_file #(
        .FTW_W (FTW_W),
        .NBANK (NBANK),
        .WR_W  (WR_W)
    ) u_banks (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_bank_i (wr_bank_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ftw_o     (ftw_all),
        .ctrl_o    (ctrl_all)
    );

    always_comb begin
        st_d = st_q;
        if (samp_en) begin
            st_d.idx = ps_sync;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_ctrl      = ctrl_all[st_q.idx];
    assign active_o      = st_q.idx;
    assign ftw_o         = ftw_all[st_q.idx];
    assign spec_inv_o    = act_ctrl.inv && (mode == MODE_QUAD);
    assign inv_cic_byp_o = act_ctrl.icb;
    assign cic_rate_o    = act_ctrl.rate;
    assign cic_byp_o     = (act_ctrl.rate == '0);
    assign scale_o       = act_ctrl.scale;

endmodule

// File: rtl/prof_select_chk.sv
module prof_select_chk #(
    parameter int unsigned FTW_W = 32,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned WR_W  = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       mode_i,
    input logic             pdclk_en_i,
    input logic [SEL_W-1:0] ps_i,
    input logic             wr_en_i,
    input logic [SEL_W-1:0] wr_bank_i,
    input logic             wr_addr_i,
    input logic [WR_W-1:0]  wr_data_i,
    input logic [SEL_W-1:0] active_o,
    input logic [FTW_W-1:0] ftw_o,
    input logic             spec_inv_o,
    input logic [7:0]       scale_o
);

    logic [1:0] since_rst;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R8: invert output only in quadrature mode
    p_inv_quad_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i != 2'd1) |-> !spec_inv_o);

    // R4: no sampling on parallel-clock cycles without enable
    p_pd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_i == 2'd1 || mode_i == 2'd2) && !pdclk_en_i) |=> $stable(active_o));

    // R6: write to active bank lands next cycle
    p_wr_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_addr_i && wr_bank_i == active_o) |=>
        ((active_o != $past(active_o)) || (ftw_o == $past(wr_data_i[FTW_W-1:0]))));

    // R7: without write or bank change, fields hold
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> (($stable(ftw_o) && $stable(scale_o)) || (active_o != $past(active_o))));

    // R3 / R2: steady tone-mode select reaches the index after three edges
    p_tone_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((since_rst == 2'd3) &&
         ($past(mode_i) == 2'd0) && ($past(mode_i, 2) == 2'd0) && ($past(mode_i, 3) == 2'd0) &&
         ($past(ps_i) == ps_i) && ($past(ps_i, 2) == ps_i) && ($past(ps_i, 3) == ps_i))
        |-> (active_o == ps_i));

endmodule

bind prof_select_top prof_select_chk #(
    .FTW_W (FTW_W),
    .SEL_W (SEL_W),
    .WR_W  (WR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .pdclk_en_i (pdclk_en_i),
    .ps_i       (ps_i),
    .wr_en_i    (wr_en_i),
    .wr_bank_i  (wr_bank_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .active_o   (active_o),
    .ftw_o      (ftw_o),
    .spec_inv_o (spec_inv_o),
    .scale_o    (scale_o)
);

// File: tb/sim_prof_select_top.sv
module sim_prof_select_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        pd_en = 1'b0;
    logic [1:0]  ps = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_bank = 2'd0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  active;
    logic [31:0] ftw;
    logic        sinv, icb, cbyp;
    logic [5:0]  rate;
    logic [7:0]  scale;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    prof_select_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pdclk_en_i(pd_en), .ps_i(ps),
        .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .active_o(active), .ftw_o(ftw), .spec_inv_o(sinv), .inv_cic_byp_o(icb),
        .cic_byp_o(cbyp), .cic_rate_o(rate), .scale_o(scale)
    );

    // bench model of bank contents
    logic [31:0] m_ftw  [4];
    logic        m_inv  [4];
    logic        m_icb  [4];
    logic [5:0]  m_rate [4];
    logic [7:0]  m_scl  [4];

    // select walk: {mode[1:0], ps[1:0]}
    localparam logic [3:0] WALK [10] = '{
        4'b00_01, 4'b00_10, 4'b00_11, 4'b00_00, 4'b01_11,
        4'b01_01, 4'b10_10, 4'b10_00, 4'b11_11, 4'b01_00
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic chk_bank(input string req, input int b);
        chk(req, 64'(active), 64'(b));
        chk(req, 64'(ftw), 64'(m_ftw[b]));
        chk(req, 64'(sinv), 64'(m_inv[b] && mode == 2'd1));
        chk(req, 64'(icb), 64'(m_icb[b]));
        chk(req, 64'(rate), 64'(m_rate[b]));
        chk(req, 64'(cbyp), 64'(m_rate[b] == 6'd0));
        chk(req, 64'(scale), 64'(m_scl[b]));
    endtask

    task automatic wr(input int b, input logic a, input logic [31:0] d);
        wr_en = 1'b1; wr_bank = 2'(b); wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
        if (!a) m_ftw[b] = d;
        else begin
            m_inv[b] = d[0]; m_icb[b] = d[1]; m_rate[b] = d[13:8]; m_scl[b] = d[23:16];
        end
    endtask

    task automatic pd_pulse();
        pd_en = 1'b1;
        step();
        pd_en = 1'b0;
        step();
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, all requirements");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int cur;
        for (int b = 0; b < 4; b++) begin
            m_ftw[b] = '0; m_inv[b] = 1'b0; m_icb[b] = 1'b0; m_rate[b] = 6'd1; m_scl[b] = 8'h80;
        end
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk_bank("R1", 0);

        // R6 loading, R9 bypass code 0 and rate 63, R10 scale extremes
        wr(0, 1'b0, 32'hA5A5_0001); wr(0, 1'b1, 32'h00FF_0001);
        wr(1, 1'b0, 32'h1234_5678); wr(1, 1'b1, 32'h0000_3F02);
        wr(2, 1'b0, 32'hFFFF_FFFF); wr(2, 1'b1, 32'hFF80_0103);
        wr(3, 1'b0, 32'h0000_0000); wr(3, 1'b1, 32'h0041_1100);
        step();
        chk_bank("R6 R9 R10", 0);

        cur = 0;
        for (int i = 0; i < 10; i++) begin
            int nb;
            mode = WALK[i][3:2];
            ps   = WALK[i][1:0];
            nb   = int'(WALK[i][1:0]);
            if (mode == 2'd1 || mode == 2'd2) begin
                pd_pulse(); pd_pulse();
                // R4 and R5: still fully on old bank after two samples
                chk_bank("R4 R5 old", cur);
                pd_pulse();
                chk_bank("R4 R2 new", nb);
            end else begin
                step(); step();
                // R3 and R5: old bank after two edges
                chk_bank("R3 R5 old", cur);
                step();
                chk_bank("R3 R2 new", nb);
            end
            cur = nb;
        end

        // R8: bank 2 has invert set; visible only in quadrature mode
        mode = 2'd0; ps = 2'd2; repeat (4) step();
        chk("R8 tone", 64'(sinv), 64'd0);
        mode = 2'd2; step();
        chk("R8 idac", 64'(sinv), 64'd0);
        mode = 2'd1; step();
        chk("R8 quad", 64'(sinv), 64'd1);
        cur = 2;

        // R7: write to inactive bank leaves outputs as they were
        wr(3, 1'b0, 32'hDEAD_BEEF);
        chk_bank("R7 ftw", cur);
        wr(1, 1'b1, 32'h0001_2A01);
        chk_bank("R7 ctrl", cur);

        // R6: write to active bank visible the next cycle
        wr_en = 1'b1; wr_bank = 2'd2; wr_addr = 1'b0; wr_data = 32'h0BAD_F00D;
        chk("R6 before", 64'(ftw), 64'(m_ftw[2]));
        step();
        wr_en = 1'b0; m_ftw[2] = 32'h0BAD_F00D;
        chk("R6 after", 64'(ftw), 64'h0BAD_F00D);
        wr(2, 1'b1, 32'h0033_0502);
        chk_bank("R6 ctrl", 2);

        // R4: parallel mode holds with no enable even after select change
        ps = 2'd3; repeat (6) step();
        chk("R4 no enable", 64'(active), 64'd2);

        // R3: reserved mode 3 samples every clock
        mode = 2'd3; repeat (3) step();
        chk_bank("R3 mode3", 3);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule